// File: doc/BRIEF.md
# Inter-Processor Interrupt Source Tracker

This block keeps the bookkeeping for software-raised interrupts passed between up to eight processors. A processor posts a request word naming an interrupt number and a way of picking destinations. For every interrupt number the block holds two square bit matrices, pending and active. Each matrix has one bit for every ordered pair of source processor and destination processor. In the flat vector of one interrupt number, the group of `NUM_CPU` bits at position `s*NUM_CPU` belongs to source `s`, and bit `d` inside that group stands for destination `d`.

A destination takes an interrupt with an acknowledge strobe. The block picks the lowest-numbered source that has that interrupt pending for the destination. It moves that single bit from pending to active and reports which source raised it. An end-of-interrupt strobe names the number, the source and the destination, and retires one active bit. A combinational query port shows, for any one destination, which numbers are pending for it and which are active for it. Priority arbitration and register decode live outside this block.

All three strobes are plain one-cycle pulses. They are accepted in every cycle with no back-pressure, because the block has no storage that can fill up. `NUM_CPU` must be a power of two.

Top module: `ipi_tracker`

## Requirements
- R1: After reset, every pending and active bit is clear, so the query port shows zero for every destination. `ack_rsp_valid` and `eoi_err` are low.
- R2: The request word carries the interrupt number in bits 3:0, the target list in bits 23:16 (bit k means processor k) and the mode in bits 25:24. Mode 2 targets only the requesting processor `req_src`.
- R3: Mode 1 targets every processor whose `cpu_en` bit is set.
- R4: Mode 0 and mode 3 both target exactly the processors named in the target list.
- R5: A destination whose `cpu_en` bit is low receives no pending bit from a request, in any mode.
- R6: One cycle after an acknowledge by destination d for number n, `ack_rsp_valid` is high. If any source has n pending for d, the lowest such source s is chosen: `ack_rsp_hit` is 1, `ack_rsp_src` is s, pending bit (n,s,d) is cleared and active bit (n,s,d) is set. Other sources stay pending.
- R7: An acknowledge that finds nothing pending returns `ack_rsp_hit` = 0 and `ack_rsp_src` = 0, and changes no state.
- R8: An end-of-interrupt for (n,s,d) clears only that active bit. Active bits of other sources for the same n and d remain.
- R9: An end-of-interrupt naming a bit that is not active raises `eoi_err` in the next cycle and changes no state. `eoi_err` is never high without an end-of-interrupt in the cycle before.
- R10: A request, an acknowledge and an end-of-interrupt in the same cycle all take effect. The acknowledge sees the pending state from before that cycle's request, and a bit set by a request in the same cycle is kept.
- R11: The query port shows, for destination `qry_dst`, bit n of `qry_pending` (or `qry_active`) set when any source has n pending (or active) for that destination. It reflects the state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_en | input | NUM_CPU | Per-processor interface enable |
| req_valid | input | 1 | Request strobe |
| req_src | input | CPU_W | Requesting processor |
| req_word | input | 32 | Request word: number, target list, mode |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_dst | input | CPU_W | Acknowledging destination |
| ack_id | input | ID_W | Interrupt number acknowledged |
| ack_rsp_valid | output | 1 | Acknowledge result valid, one cycle after the strobe |
| ack_rsp_hit | output | 1 | A pending source was found |
| ack_rsp_src | output | CPU_W | Source that raised the acknowledged interrupt |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_dst | input | CPU_W | Destination retiring the interrupt |
| eoi_src | input | CPU_W | Source of the interrupt being retired |
| eoi_id | input | ID_W | Interrupt number being retired |
| eoi_err | output | 1 | Retired bit was not active |
| qry_dst | input | CPU_W | Destination whose view is shown |
| qry_pending | output | NUM_ID | Numbers pending for qry_dst |
| qry_active | output | NUM_ID | Numbers active for qry_dst |

## Verification
Some properties are checked on every cycle. Each acknowledge is answered exactly one cycle later. A successful acknowledge leaves the reported source's active bit set. A retire of a bit that was not active raises the error flag, and the flag never rises without a retire. A valid retire always clears its bit. Destination selection under each mode, skipping of disabled processors, lowest-source ordering across repeated acknowledges and the same-cycle mix of all three strobes need sequences. Those are shown only by the bench scenarios, which compare every response and query against a reference of the pending and active matrices.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int REQ_W    = 32;
  localparam int ID_LSB   = 0;
  localparam int LIST_LSB = 16;
  localparam int MODE_LSB = 24;

  typedef enum logic [1:0] {
    TGT_LIST     = 2'd0,
    TGT_ALL_ON   = 2'd1,
    TGT_SELF     = 2'd2,
    TGT_LIST_ALT = 2'd3
  } tgt_mode_e;
endpackage

// File: rtl/ipi_req_decode.sv
module ipi_req_decode
  import ipi_pkg::*;
#(
  parameter  int NUM_CPU = 8,
  parameter  int NUM_ID  = 16,
  localparam int CPU_W   = $clog2(NUM_CPU),
  localparam int ID_W    = $clog2(NUM_ID),
  localparam int VEC_W   = NUM_CPU * NUM_CPU
) (
  input  logic                            req_valid,
  input  logic [CPU_W-1:0]                req_src,
  input  logic [REQ_W-1:0]                req_word,
  input  logic [NUM_CPU-1:0]              cpu_en,
  output logic [NUM_ID-1:0][VEC_W-1:0]    set_mask
);
  tgt_mode_e          mode;
  logic [ID_W-1:0]    id;
  logic [NUM_CPU-1:0] tgt;
  logic [VEC_W-1:0]   placed;

  always_comb begin
    mode = tgt_mode_e'(req_word[MODE_LSB +: 2]);
    id   = req_word[ID_LSB +: ID_W];
    case (mode)
      TGT_ALL_ON: tgt = cpu_en;
      TGT_SELF:   tgt = NUM_CPU'(1) << req_src;
      default:    tgt = req_word[LIST_LSB +: NUM_CPU];
    endcase
    tgt = tgt & cpu_en;  // disabled destinations never get a bit
  end

  // place target bits in the group owned by the requesting source
  for (genvar s = 0; s < NUM_CPU; s++) begin : g_place
    assign placed[s*NUM_CPU +: NUM_CPU] = (req_src == CPU_W'(s)) ? tgt : '0;
  end

  for (genvar i = 0; i < NUM_ID; i++) begin : g_id
    assign set_mask[i] = (req_valid && id == ID_W'(i)) ? placed : '0;
  end
endmodule

// File: rtl/ipi_src_pick.sv
module ipi_src_pick #(
  parameter  int NUM_CPU = 8,
  localparam int CPU_W   = $clog2(NUM_CPU),
  localparam int VEC_W   = NUM_CPU * NUM_CPU
) (
  input  logic [VEC_W-1:0] vec,
  input  logic [CPU_W-1:0] dst,
  output logic             found,
  output logic [CPU_W-1:0] src
);
  // scan from the top down so the lowest matching source wins
  always_comb begin
    found = 1'b0;
    src   = '0;
    for (int s = NUM_CPU - 1; s >= 0; s--) begin
      if (vec[s*NUM_CPU + int'(dst)]) begin
        found = 1'b1;
        src   = CPU_W'(s);
      end
    end
  end
endmodule

// File: rtl/ipi_vec_store.sv
module ipi_vec_store #(
  parameter  int NUM_CPU = 8,
  parameter  int NUM_ID  = 16,
  localparam int VEC_W   = NUM_CPU * NUM_CPU
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_ID-1:0][VEC_W-1:0] pend_set,
  input  logic [NUM_ID-1:0][VEC_W-1:0] pend_clr,
  input  logic [NUM_ID-1:0][VEC_W-1:0] act_set,
  input  logic [NUM_ID-1:0][VEC_W-1:0] act_clr,
  output logic [NUM_ID-1:0][VEC_W-1:0] pend_q,
  output logic [NUM_ID-1:0][VEC_W-1:0] act_q
);
  // set wins over clear in both matrices
  for (genvar i = 0; i < NUM_ID; i++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= '0;
        act_q[i]  <= '0;
      end else begin
        pend_q[i] <= (pend_q[i] & ~pend_clr[i]) | pend_set[i];
        act_q[i]  <= (act_q[i]  & ~act_clr[i])  | act_set[i];
      end
    end
  end
endmodule

// File: rtl/ipi_tracker.sv
module ipi_tracker
  import ipi_pkg::*;
#(
  parameter  int NUM_CPU = 8,
  parameter  int NUM_ID  = 16,
  localparam int CPU_W   = $clog2(NUM_CPU),
  localparam int ID_W    = $clog2(NUM_ID)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CPU-1:0] cpu_en,
  input  logic               req_valid,
  input  logic [CPU_W-1:0]   req_src,
  input  logic [REQ_W-1:0]   req_word,
  input  logic               ack_valid,
  input  logic [CPU_W-1:0]   ack_dst,
  input  logic [ID_W-1:0]    ack_id,
  output logic               ack_rsp_valid,
  output logic               ack_rsp_hit,
  output logic [CPU_W-1:0]   ack_rsp_src,
  input  logic               eoi_valid,
  input  logic [CPU_W-1:0]   eoi_dst,
  input  logic [CPU_W-1:0]   eoi_src,
  input  logic [ID_W-1:0]    eoi_id,
  output logic               eoi_err,
  input  logic [CPU_W-1:0]   qry_dst,
  output logic [NUM_ID-1:0]  qry_pending,
  output logic [NUM_ID-1:0]  qry_active
);
  localparam int VEC_W = NUM_CPU * NUM_CPU;
  localparam int IDX_W = 2 * CPU_W;

  logic [NUM_ID-1:0][VEC_W-1:0] pend_vec, act_vec;
  logic [NUM_ID-1:0][VEC_W-1:0] req_set, ack_mask, eoi_mask;
  logic                         pick_found;
  logic [CPU_W-1:0]             pick_src;
  logic [IDX_W-1:0]             ack_bit, eoi_bit;
  logic                         eoi_hit;
  logic [VEC_W-1:0]             qry_col;

  ipi_req_decode #(.NUM_CPU(NUM_CPU), .NUM_ID(NUM_ID)) u_dec (
    .req_valid (req_valid),
    .req_src   (req_src),
    .req_word  (req_word),
    .cpu_en    (cpu_en),
    .set_mask  (req_set)
  );

  // acknowledge looks at the state held before this cycle's updates
  ipi_src_pick #(.NUM_CPU(NUM_CPU)) u_pick (
    .vec   (pend_vec[ack_id]),
    .dst   (ack_dst),
    .found (pick_found),
    .src   (pick_src)
  );

  assign ack_bit = {pick_src, ack_dst};
  assign eoi_bit = {eoi_src, eoi_dst};
  assign eoi_hit = act_vec[eoi_id][eoi_bit];

  for (genvar i = 0; i < NUM_ID; i++) begin : g_mask
    assign ack_mask[i] = (ack_valid && pick_found && ack_id == ID_W'(i))
                         ? (VEC_W'(1) << ack_bit) : '0;
    assign eoi_mask[i] = (eoi_valid && eoi_hit && eoi_id == ID_W'(i))
                         ? (VEC_W'(1) << eoi_bit) : '0;
  end

  ipi_vec_store #(.NUM_CPU(NUM_CPU), .NUM_ID(NUM_ID)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_set (req_set),
    .pend_clr (ack_mask),
    .act_set  (ack_mask),
    .act_clr  (eoi_mask),
    .pend_q   (pend_vec),
    .act_q    (act_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_rsp_valid <= 1'b0;
      ack_rsp_hit   <= 1'b0;
      ack_rsp_src   <= '0;
      eoi_err       <= 1'b0;
    end else begin
      ack_rsp_valid <= ack_valid;
      ack_rsp_hit   <= ack_valid && pick_found;
      ack_rsp_src   <= (ack_valid && pick_found) ? pick_src : '0;
      eoi_err       <= eoi_valid && !eoi_hit;
    end
  end

  // destination column: bit qry_dst of every source group
  always_comb begin
    qry_col = '0;
    for (int s = 0; s < NUM_CPU; s++)
      for (int d = 0; d < NUM_CPU; d++)
        qry_col[s*NUM_CPU + d] = (qry_dst == CPU_W'(d));
  end

  for (genvar i = 0; i < NUM_ID; i++) begin : g_qry
    assign qry_pending[i] = |(pend_vec[i] & qry_col);
    assign qry_active[i]  = |(act_vec[i]  & qry_col);
  end
endmodule

// File: rtl/ipi_tracker_chk.sv
module ipi_tracker_chk #(
  parameter  int NUM_CPU = 8,
  parameter  int NUM_ID  = 16,
  localparam int CPU_W   = $clog2(NUM_CPU),
  localparam int ID_W    = $clog2(NUM_ID),
  localparam int VEC_W   = NUM_CPU * NUM_CPU,
  localparam int IDX_W   = 2 * CPU_W
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         ack_valid,
  input logic [CPU_W-1:0]             ack_dst,
  input logic [ID_W-1:0]              ack_id,
  input logic                         ack_rsp_valid,
  input logic                         ack_rsp_hit,
  input logic [CPU_W-1:0]             ack_rsp_src,
  input logic                         eoi_valid,
  input logic [CPU_W-1:0]             eoi_dst,
  input logic [CPU_W-1:0]             eoi_src,
  input logic [ID_W-1:0]              eoi_id,
  input logic                         eoi_err,
  input logic [NUM_ID-1:0][VEC_W-1:0] act_vec
);
  logic [ID_W-1:0]  a_id_q, e_id_q;
  logic [CPU_W-1:0] a_dst_q;
  logic [IDX_W-1:0] e_bit_q;
  logic             e_chk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_id_q  <= '0;
      a_dst_q <= '0;
      e_id_q  <= '0;
      e_bit_q <= '0;
      e_chk_q <= 1'b0;
    end else begin
      a_id_q  <= ack_id;
      a_dst_q <= ack_dst;
      e_id_q  <= eoi_id;
      e_bit_q <= {eoi_src, eoi_dst};
      e_chk_q <= eoi_valid && act_vec[eoi_id][{eoi_src, eoi_dst}]
                 && !(ack_valid && ack_id == eoi_id && ack_dst == eoi_dst);
    end
  end

  // R6: every acknowledge is answered in the next cycle
  p_ack_answer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> ack_rsp_valid);

  // R7: no response appears without an acknowledge
  p_no_stray_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |=> !ack_rsp_valid);

  // R6: reported source now holds the active bit
  p_hit_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rsp_valid && ack_rsp_hit) |-> act_vec[a_id_q][{ack_rsp_src, a_dst_q}]);

  // R8: a valid retire clears its bit
  p_eoi_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    e_chk_q |-> !act_vec[e_id_q][e_bit_q]);

  // R9: retiring an inactive bit flags an error
  p_eoi_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !act_vec[eoi_id][{eoi_src, eoi_dst}]) |=> eoi_err);

  // R9: the flag only follows a retire
  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !eoi_valid |=> !eoi_err);
endmodule

bind ipi_tracker ipi_tracker_chk #(.NUM_CPU(NUM_CPU), .NUM_ID(NUM_ID)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ack_valid     (ack_valid),
  .ack_dst       (ack_dst),
  .ack_id        (ack_id),
  .ack_rsp_valid (ack_rsp_valid),
  .ack_rsp_hit   (ack_rsp_hit),
  .ack_rsp_src   (ack_rsp_src),
  .eoi_valid     (eoi_valid),
  .eoi_dst       (eoi_dst),
  .eoi_src       (eoi_src),
  .eoi_id        (eoi_id),
  .eoi_err       (eoi_err),
  .act_vec       (act_vec)
);

// File: tb/tb_ipi_tracker.sv
module tb_ipi_tracker;
  localparam int NC = 8;
  localparam int NI = 16;
  localparam int VW = NC * NC;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [NC-1:0] cpu_en;
  logic          req_valid;
  logic [2:0]    req_src;
  logic [31:0]   req_word;
  logic          ack_valid;
  logic [2:0]    ack_dst;
  logic [3:0]    ack_id;
  logic          ack_rsp_valid, ack_rsp_hit;
  logic [2:0]    ack_rsp_src;
  logic          eoi_valid;
  logic [2:0]    eoi_dst, eoi_src;
  logic [3:0]    eoi_id;
  logic          eoi_err;
  logic [2:0]    qry_dst;
  logic [NI-1:0] qry_pending, qry_active;

  ipi_tracker dut (
    .clk(clk), .rst_n(rst_n), .cpu_en(cpu_en),
    .req_valid(req_valid), .req_src(req_src), .req_word(req_word),
    .ack_valid(ack_valid), .ack_dst(ack_dst), .ack_id(ack_id),
    .ack_rsp_valid(ack_rsp_valid), .ack_rsp_hit(ack_rsp_hit),
    .ack_rsp_src(ack_rsp_src),
    .eoi_valid(eoi_valid), .eoi_dst(eoi_dst), .eoi_src(eoi_src),
    .eoi_id(eoi_id), .eoi_err(eoi_err),
    .qry_dst(qry_dst), .qry_pending(qry_pending), .qry_active(qry_active)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [VW-1:0] mp [NI];
  logic [VW-1:0] ma [NI];
  logic [3:0]    exp_q [$];   // {hit, src}
  string         tag_q [$];

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] col(int d);
    logic [VW-1:0] c = '0;
    for (int s = 0; s < NC; s++) c[s*NC + d] = 1'b1;
    return c;
  endfunction

  task automatic query(string tag, int d);
    logic [NI-1:0] ep, ea;
    for (int i = 0; i < NI; i++) begin
      ep[i] = |(mp[i] & col(d));
      ea[i] = |(ma[i] & col(d));
    end
    qry_dst = 3'(d);
    #1;
    check({tag, " pending"}, qry_pending, ep);
    check({tag, " active"}, qry_active, ea);
  endtask

  // scoreboard monitor for acknowledge responses
  always @(negedge clk) begin
    if (rst_n && ack_rsp_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R6 unexpected response actual=1 expected=0");
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " ack hit/src"}, {ack_rsp_hit, ack_rsp_src}, e);
      end
    end
  end

  task automatic issue(string tag,
                       bit rv, int rs, int mode, int list, int rid,
                       bit av, int ad, int aid,
                       bit ev, int ed, int es, int eid);
    logic [NC-1:0] tgt;
    logic [VW-1:0] rset, aset, eclr;
    bit exp_err, hit;
    int src;
    @(negedge clk);
    rset = '0; aset = '0; eclr = '0; exp_err = 0;
    if (rv) begin
      if (mode == 1) tgt = cpu_en;
      else if (mode == 2) tgt = NC'(1) << rs;
      else tgt = NC'(list);
      tgt &= cpu_en;
      for (int d = 0; d < NC; d++) rset[rs*NC + d] = tgt[d];
    end
    if (av) begin
      hit = 0; src = 0;
      for (int s = NC - 1; s >= 0; s--)
        if (mp[aid][s*NC + ad]) begin hit = 1; src = s; end
      if (hit) aset[src*NC + ad] = 1'b1;
      exp_q.push_back({hit, 3'(src)});
      tag_q.push_back(tag);
    end
    if (ev) begin
      exp_err = !ma[eid][es*NC + ed];
      if (!exp_err) eclr[es*NC + ed] = 1'b1;
    end
    req_valid = rv; req_src = 3'(rs);
    req_word  = (32'(mode) << 24) | (32'(list) << 16) | 32'(rid);
    ack_valid = av; ack_dst = 3'(ad); ack_id = 4'(aid);
    eoi_valid = ev; eoi_dst = 3'(ed); eoi_src = 3'(es); eoi_id = 4'(eid);
    if (av) mp[aid] = mp[aid] & ~aset;
    if (rv) mp[rid] = mp[rid] | rset;
    if (ev) ma[eid] = ma[eid] & ~eclr;
    if (av) ma[aid] = ma[aid] | aset;
    @(negedge clk);
    req_valid = 0; ack_valid = 0; eoi_valid = 0;
    if (ev) check({tag, " eoi_err"}, eoi_err, exp_err);
  endtask

  task automatic req(string tag, int rs, int mode, int list, int rid);
    issue(tag, 1, rs, mode, list, rid, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic ack(string tag, int ad, int aid);
    issue(tag, 0, 0, 0, 0, 0, 1, ad, aid, 0, 0, 0, 0);
  endtask
  task automatic eoi(string tag, int ed, int es, int eid);
    issue(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1, ed, es, eid);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NI; i++) begin mp[i] = '0; ma[i] = '0; end
    rst_n = 0; cpu_en = '1; req_valid = 0; req_src = 0; req_word = 0;
    ack_valid = 0; ack_dst = 0; ack_id = 0;
    eoi_valid = 0; eoi_dst = 0; eoi_src = 0; eoi_id = 0; qry_dst = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    check("R1 ack_rsp_valid", ack_rsp_valid, 0);
    check("R1 eoi_err", eoi_err, 0);
    for (int d = 0; d < NC; d++) query("R1 reset view", d);

    // R2: self-targeted request
    req("R2 self", 3, 2, 8'hFF, 5);
    query("R2 dst3", 3);
    query("R2 dst0", 0);
    check("R2 dst3 bit5", qry_pending[5], 0);  // dst0 query left last
    query("R2 dst3 again", 3);
    check("R2 dst3 bit5 set", qry_pending[5], 1);

    // R3 and R5: broadcast to enabled processors, dst3 disabled
    cpu_en = 8'hF7;
    req("R3 all enabled", 1, 1, 0, 7);
    for (int d = 0; d < NC; d++) query("R3 broadcast view", d);
    query("R5 dst3 skipped", 3);
    check("R5 dst3 bit7 clear", qry_pending[7], 0);

    // R4: explicit list in mode 0 and mode 3
    cpu_en = '1;
    req("R4 list mode0", 0, 0, 8'h24, 2);
    req("R4 list mode3", 6, 3, 8'h01, 9);
    for (int d = 0; d < NC; d++) query("R4 list view", d);

    // R5: dst4 disabled in list mode, then re-enabled
    cpu_en = 8'hEF;
    req("R5 list with disabled", 2, 0, 8'h11, 11);
    cpu_en = '1;
    query("R5 dst4", 4);
    check("R5 dst4 bit11 clear", qry_pending[11], 0);
    query("R5 dst0", 0);

    // R6: lowest source first
    req("R6 src5", 5, 0, 8'h02, 12);
    req("R6 src2", 2, 0, 8'h02, 12);
    ack("R6 first ack", 1, 12);
    query("R6 after first", 1);
    ack("R6 second ack", 1, 12);
    query("R6 after second", 1);

    // R7: nothing pending
    ack("R7 empty ack", 1, 12);
    query("R7 unchanged", 1);
    ack("R7 empty id", 7, 15);

    // R8: retire one source, other stays
    eoi("R8 retire src2", 1, 2, 12);
    query("R8 src5 remains", 1);
    check("R8 bit12 active", qry_active[12], 1);
    eoi("R8 retire src5", 1, 5, 12);
    query("R8 all retired", 1);

    // R9: retire inactive bit
    eoi("R9 inactive", 1, 5, 12);
    query("R9 unchanged", 1);
    eoi("R9 never raised", 4, 0, 3);

    // R10: all three strobes together
    req("R10 prep id1", 3, 0, 8'h40, 1);
    ack("R10 prep ack", 6, 1);
    req("R10 prep id4", 0, 0, 8'h40, 4);
    issue("R10 combined", 1, 7, 0, 8'h40, 4, 1, 6, 4, 1, 6, 3, 1);
    query("R10 combined view", 6);
    ack("R10 later ack", 6, 4);
    issue("R10 ack before req", 1, 2, 0, 8'h08, 13, 1, 3, 13, 0, 0, 0, 0);
    query("R10 req kept", 3);

    // R11: views of several destinations
    for (int d = 0; d < NC; d++) query("R11 final view", d);

    repeat (2) @(negedge clk);
    check("R6 queue drained", exp_q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule